// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous request port and an external asynchronous static RAM with 256K words of 16 bits. On the user side a request carries a read or write flag, an address, write data and one enable bit per byte lane. The transfer uses valid/ready. The controller raises `req_ready` only while it is idle. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. Once `req_valid` is raised it must stay high with a stable payload until that edge. The payload is registered at that edge, so the user may change it right after. The response side has no back-pressure. `rsp_valid` pulses for exactly one cycle per request, and `rsp_rdata` holds the read word from that pulse until the next response.

On the memory side the controller drives the address, the active-low chip, output and write enables and one active-low strobe per byte lane. The data bus is split into an output word, an output-enable and an input word, which the chip pad ring joins into a tri-state bus. Every memory timing is counted in clock cycles. Each count is derived at elaboration from a nanosecond limit and the clock period: read access, write pulse width, and the time the memory takes to release its pins after a read. Reads and single or byte-masked writes are supported.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and directly after it, all memory enables and lane strobes are high, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is high only while the controller is idle and the chip enable is high. The request payload is registered at the accepting edge, and later changes on the request inputs do not affect that access.
- R3: A read drives chip enable and output enable low with write enable high. It holds them for RD_CYC cycles and captures the bus at the RD_CYC-th edge after acceptance. `rsp_valid` is seen in the cycle after that edge. That is at least the 85 ns access time after the address and strobes became valid.
- R4: Lane strobe bit 0 (low active) gates data bits 7:0 and bit 1 gates bits 15:8. A lane whose enable is 0 gets its strobe held high, and it returns zero in `rsp_rdata` on a read.
- R5: A write first asserts chip enable with write enable high for one cycle. It then holds write enable low for exactly WP_CYC cycles. It then raises write enable for one cycle while address, strobes and chip enable are kept. `rsp_valid` comes in that last cycle, WP_CYC+1 edges after acceptance.
- R6: A byte-masked write changes only the selected lanes of the addressed word. The other lane keeps its former value.
- R7: `mem_dq_oe` is high only while write enable is low, and output enable and write enable are never low together.
- R8: After output enable is released at the end of a read, `req_ready` stays low for TURN_CYC more cycles. The data driver is not enabled within TURN_CYC cycles of that release.
- R9: Every accepted request yields exactly one single-cycle `rsp_valid` pulse, in acceptance order.
- R10: A request with both byte enables 0 starts no memory cycle: no enable or strobe is asserted, memory is unchanged, and `rsp_valid` with `rsp_rdata` equal to 0 is seen in the cycle right after acceptance.
- R11: RD_CYC is the largest of the ceilings of access, output-enable and lane-strobe limits over the clock period. WP_CYC and TURN_CYC are the ceilings of their limits. Each count is at least 1. The defaults give 17, 12 and 7 at a 5 ns clock.
- R12: While write enable is low, address, lane strobes and write data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte lane enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, low active |
| mem_oe_n | output | 1 | Output enable, low active |
| mem_we_n | output | 1 | Write enable, low active |
| mem_bs_n | output | DATA_W/8 | Lane strobes, low active |
| mem_dq_out | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Enables the data driver |
| mem_dq_in | input | DATA_W | Data read from memory pins |

## Verification
A read's response is due RD_CYC edges after the accepting edge and a write's WP_CYC+1 edges after it. A request with no lanes enabled is answered in the cycle after acceptance. The scoreboard stamps each request with the edge count of its acceptance plus that latency. It compares the stamp at the falling edge where `rsp_valid` is seen, so early and late answers both fail. The memory model records how long address and strobes had been stable at each capture edge. It also checks strobe widths, lane preservation and turnaround gaps against the cycle counts derived from the nanosecond limits.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_TURN, ST_WSET, ST_WPUL, ST_WHLD
  } ctrl_st_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction
endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R11
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 17,
  parameter int WP_CYC   = 12,
  parameter int TURN_CYC = 7,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          be_any,
  input  logic          tmr_done,
  output logic          req_ready,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          latch,
  output logic          capture,
  output logic          release_l,
  output logic          clear_rd,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          drv_en,
  output logic          rsp_valid
);
  ctrl_st_e st_q;
  logic     accept;

  always_comb begin
    req_ready = (st_q == ST_IDLE);
    accept    = req_valid && req_ready;
    latch     = accept && be_any;
    clear_rd  = accept && !be_any;
    capture   = (st_q == ST_RD) && tmr_done;
    release_l = capture || (st_q == ST_WHLD);
    tmr_load  = 1'b0;
    tmr_val   = '0;
    if (latch && !req_write) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(RD_CYC - 1);
    end else if (capture) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(TURN_CYC - 1);
    end else if (st_q == ST_WSET) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(WP_CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      drv_en    <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (clear_rd) begin
            rsp_valid <= 1'b1;
          end else if (latch && req_write) begin
            ce_n <= 1'b0;
            st_q <= ST_WSET;
          end else if (latch) begin
            ce_n <= 1'b0;
            oe_n <= 1'b0;
            st_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (tmr_done) begin
            rsp_valid <= 1'b1;
            ce_n      <= 1'b1;
            oe_n      <= 1'b1;
            st_q      <= ST_TURN;
          end
        end
        ST_TURN: begin
          if (tmr_done) st_q <= ST_IDLE;
        end
        ST_WSET: begin
          we_n   <= 1'b0;
          drv_en <= 1'b1;
          st_q   <= ST_WPUL;
        end
        ST_WPUL: begin
          if (tmr_done) begin
            we_n      <= 1'b1;
            drv_en    <= 1'b0;
            rsp_valid <= 1'b1;
            st_q      <= ST_WHLD;
          end
        end
        ST_WHLD: begin
          ce_n <= 1'b1;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // cycles the output enable has been low, for the access-time check
  logic [CW:0] rd_age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_age_q <= '0;
    else if (!oe_n) rd_age_q <= rd_age_q + 1'b1;
    else            rd_age_q <= '0;
  end

  // R3
  rd_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> (rd_age_q >= (CW+1)'(RD_CYC)));
  // R7
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
  // R5
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> rsp_valid);
  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && we_n && oe_n));
  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !req_ready) |=> !rsp_valid);
endmodule

// File: rtl/sram_lane_path.sv
`timescale 1ns/1ps
module sram_lane_path #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch,
  input  logic              release_l,
  input  logic              capture,
  input  logic              clear_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_bs_n,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (latch) addr_q <= req_addr;
  end
  assign mem_addr = addr_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic       bs_q;
    logic [7:0] wd_q;
    logic [7:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bs_q <= 1'b1;
        wd_q <= '0;
        rd_q <= '0;
      end else begin
        if (latch) begin
          bs_q <= ~req_be[g];
          wd_q <= req_wdata[g*8 +: 8];
        end else if (release_l) begin
          bs_q <= 1'b1;
        end
        if (capture)       rd_q <= bs_q ? 8'h00 : dq_in[g*8 +: 8];
        else if (clear_rd) rd_q <= 8'h00;
      end
    end

    assign mem_bs_n[g]          = bs_q;
    assign dq_out[g*8 +: 8]     = wd_q;
    assign rsp_rdata[g*8 +: 8]  = rd_q;
  end

  // R4
  lane_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> (mem_bs_n == ~$past(req_be)));
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 5,
  parameter int T_ACC_NS  = 85,
  parameter int T_OE_NS   = 40,
  parameter int T_BS_NS   = 40,
  parameter int T_WP_NS   = 60,
  parameter int T_TURN_NS = 35,
  localparam int LANES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_bs_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int ACC_C    = ns_to_cyc(T_ACC_NS, CLK_NS);
  localparam int OE_C     = ns_to_cyc(T_OE_NS, CLK_NS);
  localparam int BS_C     = ns_to_cyc(T_BS_NS, CLK_NS);
  localparam int RD_A     = (ACC_C > OE_C) ? ACC_C : OE_C;
  localparam int RD_CYC   = (RD_A > BS_C) ? RD_A : BS_C;
  localparam int WP_CYC   = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int TURN_CYC = ns_to_cyc(T_TURN_NS, CLK_NS);
  localparam int MAX_A    = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int MAX_C    = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
  localparam int CW       = $clog2(MAX_C + 1);

  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic          latch, capture, release_l, clear_rd;

  sram_wait_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .TURN_CYC(TURN_CYC), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .be_any(|req_be), .tmr_done(tmr_done), .req_ready(req_ready),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .latch(latch), .capture(capture),
    .release_l(release_l), .clear_rd(clear_rd), .ce_n(mem_ce_n),
    .oe_n(mem_oe_n), .we_n(mem_we_n), .drv_en(mem_dq_oe), .rsp_valid(rsp_valid)
  );

  sram_lane_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rst_n(rst_n), .latch(latch), .release_l(release_l),
    .capture(capture), .clear_rd(clear_rd), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_bs_n(mem_bs_n), .dq_out(mem_dq_out),
    .rsp_rdata(rsp_rdata)
  );

  // cycles since output enable was last low, saturating
  logic [CW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    gap_q <= CW'(TURN_CYC);
    else if (!mem_oe_n)            gap_q <= '0;
    else if (gap_q < CW'(TURN_CYC)) gap_q <= gap_q + 1'b1;
  end

  // R8
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (gap_q >= CW'(TURN_CYC)));
  // R7
  drive_in_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);
  // R12
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |->
      ($stable(mem_addr) && $stable(mem_bs_n) && $stable(mem_dq_out)));
endmodule

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
  localparam int CLK_NS   = 5;
  localparam int RD_CYC   = 17;  // max(ceil(85/5), ceil(40/5), ceil(40/5))
  localparam int WP_CYC   = 12;  // ceil(60/5)
  localparam int TURN_CYC = 7;   // ceil(35/5)
  localparam real T_ACC   = 85.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [17:0] mem_addr;
  logic [1:0]  mem_bs_n;

  always #2.5 clk = ~clk;

  sram_async_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input int a);
    return 16'(a * 7 + 16'h0321);
  endfunction

  // behavioural memory model
  logic [15:0] mdata [int];
  real t_chg = 0.0, last_age = 0.0;
  bit  prev_we_low = 1'b0;
  always @(mem_addr or mem_ce_n or mem_oe_n or mem_bs_n) t_chg = $realtime;
  always @(posedge clk) if (rst_n && !mem_oe_n) last_age = $realtime - t_chg;

  always @(negedge clk) begin
    logic [15:0] w;
    w = mdata.exists(int'(mem_addr)) ? mdata[int'(mem_addr)] : init_word(int'(mem_addr));
    if (rst_n && prev_we_low && mem_we_n && !mem_ce_n) begin
      if (!mem_bs_n[0]) w[7:0]  = mem_dq_out[7:0];
      if (!mem_bs_n[1]) w[15:8] = mem_dq_out[15:8];
      mdata[int'(mem_addr)] = w;
    end
    mem_dq_in = 16'h5A5A;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      if (!mem_bs_n[0]) mem_dq_in[7:0]  = w[7:0];
      if (!mem_bs_n[1]) mem_dq_in[15:8] = w[15:8];
    end
    prev_we_low = rst_n && !mem_we_n;
  end

  // scoreboard
  typedef struct { bit rd; bit [1:0] be; logic [15:0] exp; int due; } item_t;
  item_t q[$];
  logic [15:0] shadow [int];

  task automatic send(input bit wr, input logic [17:0] a, input logic [15:0] d,
                      input logic [1:0] be);
    item_t it;
    logic [15:0] s;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    s = shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(int'(a));
    it.rd = !wr; it.be = be; it.due = cyc + 1;
    if (be == 2'b00) begin
      it.exp = 16'h0000;
    end else if (wr) begin
      if (be[0]) s[7:0]  = d[7:0];
      if (be[1]) s[15:8] = d[15:8];
      shadow[int'(a)] = s;
      it.exp = 16'h0000;
      it.due += WP_CYC + 1;
    end else begin
      it.exp = {be[1] ? s[15:8] : 8'h00, be[0] ? s[7:0] : 8'h00};
      it.due += RD_CYC;
    end
    q.push_back(it);
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_be = ~be;  // R2: later payload ignored
  endtask

  // response monitor and strobe monitor
  int   we_len = 0, oe_rise_cyc = -1000;
  bit   prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1, prev_drv = 1'b0;
  logic [17:0] h_addr; logic [1:0] h_bs; logic [15:0] h_dq;
  int   viol7 = 0, viol12 = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        chk(q.size() != 0, "R9", "response without request", 1, 0);
        if (q.size() != 0) begin
          item_t it;
          it = q.pop_front();
          chk(cyc == it.due, it.be == 0 ? "R10" : (it.rd ? "R3/R11" : "R5/R11"),
              "response cycle", cyc, it.due);
          if (it.rd || it.be == 0)
            chk(rsp_rdata == it.exp, it.be == 0 ? "R10" : "R4/R6", "read data",
                rsp_rdata, it.exp);
          if (it.rd && it.be != 0)
            chk(last_age >= T_ACC, "R3", "access age at capture ns",
                longint'(last_age), 85);
        end
      end
      if (mem_dq_oe && mem_we_n) viol7++;
      if (!mem_oe_n && !mem_we_n) viol7++;
      if (!mem_we_n && prev_we) begin
        chk(!prev_ce, "R5", "chip enable set up before write enable", prev_ce, 0);
        h_addr = mem_addr; h_bs = mem_bs_n; h_dq = mem_dq_out; we_len = 1;
      end else if (!mem_we_n) begin
        we_len++;
        if (mem_addr != h_addr || mem_bs_n != h_bs || mem_dq_out != h_dq) viol12++;
      end
      if (mem_we_n && !prev_we) begin
        chk(we_len == WP_CYC, "R5", "write pulse cycles", we_len, WP_CYC);
        chk(!mem_ce_n, "R5", "chip enable held after write", mem_ce_n, 0);
      end
      if (mem_oe_n && !prev_oe) oe_rise_cyc = cyc;
      if (mem_dq_oe && !prev_drv)
        chk(cyc - oe_rise_cyc > TURN_CYC, "R8", "release to drive cycles",
            cyc - oe_rise_cyc, TURN_CYC + 1);
      prev_we = mem_we_n; prev_oe = mem_oe_n; prev_ce = mem_ce_n; prev_drv = mem_dq_oe;
    end
  end

  task automatic r1_state(input string when);
    chk(mem_ce_n && mem_oe_n && mem_we_n && mem_bs_n == 2'b11, "R1",
        {when, " strobes"}, {mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n}, 5'h1F);
    chk(!mem_dq_oe && !rsp_valid && req_ready, "R1", {when, " oe/rsp/ready"},
        {mem_dq_oe, rsp_valid, req_ready}, 3'b001);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (TURN_CYC + 3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    r1_state("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    r1_state("after reset");

    // full-word write and read
    send(1'b1, 18'h00010, 16'h1234, 2'b11);
    send(1'b0, 18'h00010, 16'h0000, 2'b11);
    // R6 byte-masked writes
    send(1'b1, 18'h00010, 16'hAACD, 2'b01);
    send(1'b0, 18'h00010, 16'h0000, 2'b11);
    send(1'b1, 18'h00010, 16'hEF77, 2'b10);
    send(1'b0, 18'h00010, 16'h0000, 2'b11);
    // R4 single-lane reads of untouched word
    send(1'b0, 18'h00020, 16'h0000, 2'b01);
    send(1'b0, 18'h00020, 16'h0000, 2'b10);
    // R10 no-lane requests
    send(1'b1, 18'h00010, 16'hFFFF, 2'b00);
    send(1'b0, 18'h00010, 16'h0000, 2'b00);
    send(1'b0, 18'h00010, 16'h0000, 2'b11);
    drain();

    // R8 ready held low through access plus turnaround
    begin
      int n = 0;
      send(1'b0, 18'h00020, 16'h0000, 2'b11);
      @(negedge clk);
      while (!req_ready && n < 1000) begin n++; @(negedge clk); end
      chk(n == RD_CYC + TURN_CYC, "R8", "ready-low cycles after read", n,
          RD_CYC + TURN_CYC);
    end
    drain();

    // R8 read followed at once by write; address boundaries
    send(1'b0, 18'h00020, 16'h0000, 2'b11);
    send(1'b1, 18'h3FFFF, 16'hC0DE, 2'b11);
    send(1'b1, 18'h00000, 16'hB00F, 2'b11);
    send(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
    send(1'b0, 18'h00000, 16'h0000, 2'b11);
    drain();

    chk(viol7 == 0, "R7", "driver/enable overlap count", viol7, 0);
    chk(viol12 == 0, "R12", "changes under write enable", viol12, 0);
    chk(q.size() == 0, "R9", "pending responses", q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=0 pending", q.size());
    finish_run();
  end
endmodule